// File: doc/BRIEF.md
# Integer-Ratio Clock Enable Generator

This block sits on a fast core clock and produces the timing for a slower synchronous bus that runs at an integer fraction of that clock. It drives two outputs. One is a single-cycle enable strobe that marks the last fast cycle of each slow period. The other is a registered divided clock whose rising edge comes exactly one fast cycle after each strobe. The divide ratio is not fixed at build time. Software or a power controller picks it at run time through a ratio select and a change request, so one instance serves every supported ratio.

A ratio change is risky while traffic is in flight, so the block only switches when the standby input says the system is quiet. Even then, the new ratio is loaded only when the running slow period has finished. A request made outside standby is held until standby arrives. A later valid request replaces a held one. A select value of zero or above the largest supported ratio is dropped.

Control is a three-state machine:
- `ST_IDLE` is held during reset.
- `IDLE_TO_RUN` fires on the first clock edge after reset is released.
- In `ST_RUN` the ratio is stable. `RUN_TO_WAIT` fires on any valid change request.
- In `ST_WAIT` a new ratio is held. `WAIT_TO_RUN` fires when standby is high on the last cycle of a slow period, and the held ratio is then loaded.
- `WAIT_TO_WAIT` covers two cases: a wait that continues, and a valid request that arrives in the same cycle as the load, which starts a fresh hold.

Top module: `ratio_clken_gen`

## Requirements
- R1: While reset (active low) is asserted, the enable and the divided clock are both 0, and the current ratio is 1.
- R2: After reset is released, the enable is first high in the fast cycle that follows the first rising edge at which reset is seen deasserted.
- R3: At every ratio of 2 or more, the divided clock is high in the fast cycle right after each enable cycle. Every rising edge of the divided clock comes one fast cycle after an enable cycle.
- R4: At ratio N, the enable is high for one fast cycle in every N, with exactly N-1 low cycles between pulses.
- R5: Within each slow period at ratio N, the divided clock is high for the first max(1, floor(N/2)) fast cycles after the enable and low for the rest.
- R6: At ratio 1, the enable and the divided clock are both high in every fast cycle.
- R7: A valid change request made while standby is low does not alter the running ratio. The request is applied once standby is high.
- R8: A new ratio is loaded only at the end of a fast cycle in which the enable is high and standby is high. The slow period in progress always completes at its old length.
- R9: A change request whose select is 0 or greater than the maximum ratio is ignored. The running ratio stays, and nothing becomes pending.
- R10: A valid request made while another is pending replaces the pending ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | RATIO_W | Requested divide ratio, valid range 1..MAX_RATIO |
| change_req | input | 1 | One-cycle request to adopt ratio_sel |
| standby | input | 1 | High when the system is quiet enough for a ratio change |
| slow_en | output | 1 | One-cycle enable in the last fast cycle of each slow period |
| slow_clk | output | 1 | Registered divided clock, rising one fast cycle after slow_en |

## Verification
The bench builds the block with a 3-bit select and a maximum ratio of 5. This makes ratios 4 and 5 reachable, where the high phase of the divided clock lasts two cycles instead of one. It also leaves the codes 6 and 7 free for the out-of-range case, alongside zero. Directed sequences walk the ratio through 1, 2, 3, 1, 5 and 4. Along the way they hold requests pending with standby low, replace a pending value, and place a request in the middle of a ratio-3 period, so the old period is seen completing before the switch.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    // Control states of the ratio manager
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // held in reset
        ST_RUN  = 2'd1,   // ratio stable, no change pending
        ST_WAIT = 2'd2    // a new ratio is held until standby and a period boundary
    } rcg_state_t;

endpackage

// File: rtl/rcg_ctrl.sv
module rcg_ctrl
    import rcg_pkg::*;
#(
    parameter int RATIO_W   = 2,
    parameter int MAX_RATIO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               change_req,
    input  logic               standby,
    input  logic               at_zero,
    output logic               active,
    output logic               apply,
    output logic [RATIO_W-1:0] cur_ratio,
    output logic [RATIO_W-1:0] load_ratio
);

    localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] MAX_R = RATIO_W'(MAX_RATIO);

    rcg_state_t         state_q, state_d;
    logic [RATIO_W-1:0] cur_q;
    logic [RATIO_W-1:0] pend_q;
    logic               sel_ok;

    // A request counts only when its select lies inside 1..MAX_RATIO
    assign sel_ok = change_req && (ratio_sel >= ONE_R) && (ratio_sel <= MAX_R);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and decoded outputs
    always_comb begin
        state_d    = state_q;
        active     = 1'b1;
        apply      = 1'b0;
        load_ratio = cur_q;
        unique case (state_q)
            ST_IDLE: begin
                active  = 1'b0;
                state_d = ST_RUN;                     // IDLE_TO_RUN
            end
            ST_RUN: begin
                if (sel_ok) state_d = ST_WAIT;        // RUN_TO_WAIT
            end
            ST_WAIT: begin
                if (standby && at_zero) begin
                    apply      = 1'b1;
                    load_ratio = pend_q;
                    state_d    = sel_ok ? ST_WAIT : ST_RUN;  // WAIT_TO_WAIT / WAIT_TO_RUN
                end
            end
            default: begin
                active  = 1'b0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // Ratio registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= ONE_R;
            pend_q <= ONE_R;
        end else begin
            if (apply)  cur_q  <= pend_q;
            if (sel_ok) pend_q <= ratio_sel;
        end
    end

    assign cur_ratio = cur_q;

    // R7: without standby the running ratio never moves
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !standby |=> $stable(cur_ratio));

    // R8: the ratio only changes after a period-ending cycle
    p_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_ratio) |-> $past(at_zero && standby));

    // R9: the running ratio always stays in the legal range
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ratio >= ONE_R) && (cur_ratio <= MAX_R));

endmodule

// File: rtl/rcg_counter.sv
module rcg_counter #(
    parameter int RATIO_W = 2,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [RATIO_W-1:0] load_ratio,
    output logic               at_zero
);

    logic [CNT_W-1:0] cnt_q;

    assign at_zero = (cnt_q == '0);

    // Down-counter: reloads with ratio-1 when it reaches zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (at_zero) begin
            cnt_q <= CNT_W'(load_ratio - RATIO_W'(1));
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/rcg_clkout.sv
module rcg_clkout #(
    parameter int RATIO_W = 2,
    parameter int CNT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               slow_en,
    input  logic [RATIO_W-1:0] load_ratio,
    output logic               slow_clk
);

    logic             clk_q;
    logic [CNT_W-1:0] hrem_q;

    // Number of high fast cycles in a slow period: max(1, floor(r/2))
    function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] r);
        logic [RATIO_W-1:0] h;
        h = r >> 1;
        return (h == '0) ? RATIO_W'(1) : h;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            hrem_q <= '0;
        end else if (!active) begin
            clk_q  <= 1'b0;
            hrem_q <= '0;
        end else if (slow_en) begin
            clk_q  <= 1'b1;
            hrem_q <= CNT_W'(high_len(load_ratio) - RATIO_W'(1));
        end else if (hrem_q != '0) begin
            clk_q  <= 1'b1;
            hrem_q <= hrem_q - CNT_W'(1);
        end else begin
            clk_q  <= 1'b0;
        end
    end

    assign slow_clk = clk_q;

    // R3: the divided clock is high the cycle after every enable
    p_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slow_en |=> slow_clk);

    // R3: every rising edge is preceded by an enable cycle
    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_clk) |-> $past(slow_en));

endmodule

// File: rtl/ratio_clken_gen.sv
module ratio_clken_gen #(
    parameter int RATIO_W   = 2,
    parameter int MAX_RATIO = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_sel,
    input  logic               change_req,
    input  logic               standby,
    output logic               slow_en,
    output logic               slow_clk
);

    localparam int CNT_W = $clog2(MAX_RATIO + 1);

    logic               active;
    logic               apply;
    logic               at_zero;
    logic [RATIO_W-1:0] cur_ratio;
    logic [RATIO_W-1:0] load_ratio;

    rcg_ctrl #(.RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_sel  (ratio_sel),
        .change_req (change_req),
        .standby    (standby),
        .at_zero    (at_zero),
        .active     (active),
        .apply      (apply),
        .cur_ratio  (cur_ratio),
        .load_ratio (load_ratio)
    );

    rcg_counter #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .load_ratio (load_ratio),
        .at_zero    (at_zero)
    );

    assign slow_en = active && at_zero;

    rcg_clkout #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_clkout (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .slow_en    (slow_en),
        .load_ratio (load_ratio),
        .slow_clk   (slow_clk)
    );

    // R6: a steady ratio of one enables every cycle
    p_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur_ratio == RATIO_W'(1) && $stable(cur_ratio)) |-> slow_en);

    // R1: nothing toggles while reset is held
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!slow_clk && (!slow_en || rst_n)));

endmodule

// File: tb/ratio_clken_gen_bench.sv
module ratio_clken_gen_bench;

    localparam int RW  = 3;
    localparam int MAX = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] ratio_sel = '0;
    logic          change_req = 1'b0;
    logic          standby = 1'b0;
    logic          slow_en;
    logic          slow_clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    ratio_clken_gen #(.RATIO_W(RW), .MAX_RATIO(MAX)) u_ratio_clken_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_sel  (ratio_sel),
        .change_req (change_req),
        .standby    (standby),
        .slow_en    (slow_en),
        .slow_clk   (slow_clk)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung (all requirements) actual=%0d expected<=100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int hi_len(input int r);
        return (r / 2 == 0) ? 1 : r / 2;
    endfunction

    task automatic request(input int val);
        ratio_sel  = RW'(val);
        change_req = 1'b1;
        step();
        change_req = 1'b0;
    endtask

    task automatic sync_en(input string req);
        for (int i = 0; i < 20; i++) begin
            if (slow_en) return;
            step();
        end
        check(req, 0, 1);   // no enable seen
    endtask

    // Checks n whole periods of ratio r, starting from an enable cycle
    task automatic check_periods(input int r, input int n, input string req);
        sync_en(req);
        for (int p = 0; p < n; p++) begin
            for (int k = 0; k < r; k++) begin
                step();
                check({req, " slow_clk"}, int'(slow_clk), (k < hi_len(r)) ? 1 : 0);
                check({req, " slow_en"},  int'(slow_en),  (k == r - 1) ? 1 : 0);
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) begin
            step();
            check("R1 slow_en in reset", int'(slow_en), 0);
            check("R1 slow_clk in reset", int'(slow_clk), 0);
        end
        rst_n = 1'b1;
        check("R2 enable before first edge", int'(slow_en), 0);
        step();
        check("R2 first enable", int'(slow_en), 1);
        check("R2 clk low in first cycle", int'(slow_clk), 0);
        step();
        check("R3 first rise after enable", int'(slow_clk), 1);
    endtask

    task automatic t_unity();
        check_periods(1, 5, "R6");
    endtask

    task automatic t_to_two();
        standby = 1'b1;
        request(2);
        check_periods(2, 4, "R4");
        standby = 1'b0;
    endtask

    task automatic t_pending();
        request(3);
        repeat (7) step();
        check_periods(2, 3, "R7 held");
        standby = 1'b1;
        check_periods(3, 3, "R7 applied");
        standby = 1'b0;
    endtask

    task automatic t_boundary();
        sync_en("R8");
        step();
        standby = 1'b1;
        check("R8 mid clk", int'(slow_clk), 1);
        check("R8 mid en", int'(slow_en), 0);
        request(1);
        check("R8 old period clk", int'(slow_clk), 0);
        check("R8 old period en", int'(slow_en), 0);
        step();
        check("R8 old period end en", int'(slow_en), 1);
        check("R8 old period end clk", int'(slow_clk), 0);
        step();
        check("R8 new ratio en", int'(slow_en), 1);
        check("R8 new ratio clk", int'(slow_clk), 1);
        check_periods(1, 3, "R8");
        standby = 1'b0;
    endtask

    task automatic t_replace();
        request(4);
        step();
        request(5);
        repeat (4) step();
        check_periods(1, 2, "R10 held");
        standby = 1'b1;
        check_periods(5, 3, "R10");
    endtask

    task automatic t_invalid();
        request(0);
        check_periods(5, 2, "R9 zero");
        request(7);
        request(6);
        check_periods(5, 2, "R9 high");
        request(4);
        check_periods(4, 3, "R5");
        standby = 1'b0;
    endtask

    initial begin
        t_reset();
        t_unity();
        t_to_two();
        t_pending();
        t_boundary();
        t_replace();
        t_invalid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule